// File: doc/BRIEF.md
# Memory-card SPI start-up sequencer

This block brings a freshly powered or freshly inserted memory card into SPI mode and waits until the card reports that it is ready. It owns the card's chip-select line. It exchanges whole bytes with the card through an external byte shifter. The block asks for one byte with a single-cycle start pulse and waits for the shifter's single-cycle completion pulse, which carries the byte received in that exchange.

After a start request the block raises chip select and clocks out filler bytes of 0xFF while the card is deselected. It then selects the card and issues the reset command. After that it polls with the readiness command until the card answers 0x00 or the retry budget runs out. An internal command framer builds each six-byte command (a token, a 32-bit argument and a check byte) and collects the response byte that follows.

The block ends in one of two states: done, or error with a captured response byte. In both cases it deselects the card and sends one more filler byte. A new start request from either end state runs the whole sequence again.

Top module: `card_spi_init`

## Requirements
- R1: While reset is applied and after it is released, chip select is high, both result flags are low and no byte exchange is started until `start_i` is pulsed.
- R2: On start, chip select is high and PRE_BYTES+1 bytes (default 11), all 0xFF, are exchanged before chip select falls: one filler for the select change, then the PRE_BYTES preamble bytes.
- R3: When chip select falls, exactly one 0xFF byte is exchanged before the first command byte is sent.
- R4: A command is six bytes sent in this order: token 0x40|index, the argument most significant byte first, then a check byte. The reset command is 0x40 00 00 00 00 0x95 and is sent once per sequence.
- R5: A command's response is the first byte other than 0xFF among up to RESP_WINDOW (default 8) bytes read after the frame, with 0xFF sent while reading. If every byte read is 0xFF, the response is 0xFF.
- R6: A reset response other than 0x01 ends the sequence with `init_err_o` high, `err_stage_o` = 0 and `err_code_o` equal to that response. No readiness command is sent in that case.
- R7: After a 0x01 reset response, the readiness command 0x41 00 00 00 00 0xFF is sent repeatedly. Polling stops at the first 0x00 response, which ends the sequence with `init_done_o` high.
- R8: If POLL_MAX (default 8) readiness commands all get a response other than 0x00, the sequence ends with `init_err_o` high, `err_stage_o` = 1 and `err_code_o` equal to the last response.
- R9: At the end of a sequence, chip select is raised and one 0xFF byte is exchanged before the result flag rises. At most one flag is high at any time, and a flag is only high while chip select is high. The error code stays unchanged while the error flag is held.
- R10: A start request while a sequence is running has no effect.
- R11: A start request while done or error is shown clears the flag on the next cycle and reruns the full sequence from the preamble.
- R12: At most one byte exchange is outstanding. A start pulse lasts one cycle and is never issued before the previous exchange has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to run the start-up sequence |
| xfer_start_o | output | 1 | One-cycle request to the byte shifter |
| xfer_tx_o | output | 8 | Byte to send, valid with `xfer_start_o` |
| xfer_done_i | input | 1 | One-cycle completion pulse from the byte shifter |
| xfer_rx_i | input | 8 | Byte received, valid with `xfer_done_i` |
| card_cs_o | output | 1 | Chip-select line level (1 = card deselected) |
| init_done_o | output | 1 | Card is ready |
| init_err_o | output | 1 | Sequence failed |
| err_stage_o | output | 1 | Failing step: 0 = reset, 1 = readiness poll |
| err_code_o | output | 8 | Response byte that caused the failure |

## Verification
The bench models the card: it replies after a random number of 0xFF bytes and becomes ready after a chosen number of polls, or never. Alongside random runs it targets these corner cases:
- a card that is ready on the eighth and last poll, where an off-by-one retry limit would report an error;
- a reset reply at the latest position the response window allows, and one position later, where a wrong window length would either miss the reply or accept it late;
- a wrong reset reply, which must not be followed by any readiness command;
- a card that stays busy, whose last reply must appear as the error code.

It also counts the deselected filler bytes and the single byte sent after the select change. A sequencer that dropped the select-change fillers, or that restarted on a start request made mid-run, would produce different counts.

// File: rtl/card_spi_init_pkg.sv
// Package: shared state encoding and protocol constants for the card
// start-up sequencer.
package card_spi_init_pkg;

    // Top-level sequence states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_RESET,
        ST_POLL,
        ST_DONE,
        ST_ERROR
    } seq_state_t;

    localparam logic [7:0] FILL_BYTE   = 8'hFF;  // idle-line value sent while reading
    localparam logic [5:0] IDX_RESET   = 6'd0;   // go-to-idle / enter SPI mode
    localparam logic [5:0] IDX_POLL    = 6'd1;   // readiness poll
    localparam logic [7:0] CRC_RESET   = 8'h95;  // valid check byte for the reset frame
    localparam logic [7:0] RESP_IDLE   = 8'h01;  // reset accepted, card busy
    localparam logic [7:0] RESP_READY  = 8'h00;  // card ready

    // Command token: start bit 0, transmission bit 1, then the 6-bit index.
    function automatic logic [7:0] cmd_token(input logic [5:0] idx);
        return {2'b01, idx};
    endfunction

endpackage

// File: rtl/card_spi_init_framer.sv
// Module: card_spi_init_framer
// Sends one six-byte command (token, 32-bit argument MSB first, check byte)
// through the byte port, then reads up to RESP_WINDOW bytes with 0xFF on the
// line and returns the first byte that is not 0xFF (or 0xFF if none arrives).
// Assumes: go_i is only pulsed while active_o is low; the byte port completes
// every requested exchange with a single-cycle done pulse.
module card_spi_init_framer
    import card_spi_init_pkg::*;
#(
    parameter int RESP_WINDOW = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go_i,
    input  logic [5:0]  cmd_i,
    input  logic [31:0] arg_i,
    input  logic [7:0]  crc_i,
    output logic        resp_valid_o,
    output logic [7:0]  resp_o,
    output logic        active_o,
    output logic        bx_start_o,
    output logic [7:0]  bx_tx_o,
    input  logic        bx_done_i,
    input  logic [7:0]  bx_rx_i
);

    localparam int FRAME_LEN = 6;
    localparam int CNT_MAX   = (RESP_WINDOW > FRAME_LEN) ? RESP_WINDOW : FRAME_LEN;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam int FRAME_W   = FRAME_LEN * 8;

    typedef enum logic [2:0] {F_IDLE, F_TX, F_TXW, F_RX, F_RXW} fr_state_t;

    fr_state_t          st;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] frame;

    // Frame sequencing: load, shift out, then collect the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= F_IDLE;
            cnt          <= '0;
            frame        <= {FRAME_LEN{FILL_BYTE}};
            resp_o       <= FILL_BYTE;
            resp_valid_o <= 1'b0;
        end else begin
            resp_valid_o <= 1'b0;
            case (st)
                F_IDLE: begin
                    if (go_i) begin
                        frame <= {cmd_token(cmd_i), arg_i, crc_i};
                        cnt   <= '0;
                        st    <= F_TX;
                    end
                end
                F_TX:  st <= F_TXW;
                F_TXW: begin
                    if (bx_done_i) begin
                        frame <= {frame[FRAME_W-9:0], FILL_BYTE};
                        if (cnt == CNT_W'(FRAME_LEN - 1)) begin
                            cnt <= '0;
                            st  <= F_RX;
                        end else begin
                            cnt <= cnt + 1'b1;
                            st  <= F_TX;
                        end
                    end
                end
                F_RX:  st <= F_RXW;
                F_RXW: begin
                    if (bx_done_i) begin
                        if (bx_rx_i != FILL_BYTE || cnt == CNT_W'(RESP_WINDOW - 1)) begin
                            resp_o       <= bx_rx_i;
                            resp_valid_o <= 1'b1;
                            st           <= F_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                            st  <= F_RX;
                        end
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

    // Byte-port request: one cycle per byte; the drained frame reads as 0xFF.
    always_comb begin
        bx_start_o = (st == F_TX) || (st == F_RX);
        bx_tx_o    = frame[FRAME_W-1 -: 8];
        active_o   = (st != F_IDLE);
    end

endmodule

// File: rtl/card_spi_init_port_mux.sv
// Module: card_spi_init_port_mux
// Shares the single byte port between the sequencer (filler bytes) and the
// command framer. Completion pulses are steered to the current owner only.
// Assumes: ownership changes only while no exchange is outstanding.
module card_spi_init_port_mux (
    input  logic       sel_framer_i,
    input  logic       ctrl_start_i,
    input  logic [7:0] ctrl_tx_i,
    input  logic       frm_start_i,
    input  logic [7:0] frm_tx_i,
    input  logic       done_i,
    output logic       start_o,
    output logic [7:0] tx_o,
    output logic       ctrl_done_o,
    output logic       frm_done_o
);

    // Select the owner's request and route the completion back to it.
    always_comb begin
        start_o     = sel_framer_i ? frm_start_i : ctrl_start_i;
        tx_o        = sel_framer_i ? frm_tx_i    : ctrl_tx_i;
        ctrl_done_o = done_i && !sel_framer_i;
        frm_done_o  = done_i &&  sel_framer_i;
    end

endmodule

// File: rtl/card_spi_init_ctrl.sv
// Module: card_spi_init_ctrl
// Sequence controller: deselected filler preamble, select change, reset
// command, bounded readiness polling, and the closing deselect filler.
// Holds the result flags and the captured error response.
// Assumes: the framer returns exactly one response per go pulse.
module card_spi_init_ctrl
    import card_spi_init_pkg::*;
#(
    parameter int PRE_BYTES = 10,
    parameter int POLL_MAX  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic       cmd_go_o,
    output logic [5:0] cmd_idx_o,
    output logic [7:0] cmd_crc_o,
    input  logic       resp_valid_i,
    input  logic [7:0] resp_i,
    output logic       use_framer_o,
    output logic       bx_start_o,
    input  logic       bx_done_i,
    output logic       cs_high_o,
    output logic       init_done_o,
    output logic       init_err_o,
    output logic       err_stage_o,
    output logic [7:0] err_code_o
);

    // Filler before select (1) + preamble + filler after select (1).
    localparam int PRE_TOTAL = PRE_BYTES + 2;
    localparam int PC_W      = $clog2(PRE_TOTAL + 1);
    localparam int PL_W      = $clog2(POLL_MAX + 1);

    seq_state_t      st;
    logic [PC_W-1:0] pre_cnt;
    logic [PL_W-1:0] poll_cnt;
    logic            bx_wait;
    logic            go_sent;
    logic            tail_busy;

    // Main sequence register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            pre_cnt     <= '0;
            poll_cnt    <= '0;
            bx_wait     <= 1'b0;
            go_sent     <= 1'b0;
            tail_busy   <= 1'b0;
            cs_high_o   <= 1'b1;
            err_stage_o <= 1'b0;
            err_code_o  <= 8'h00;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        st      <= ST_PREAMBLE;
                        pre_cnt <= '0;
                        bx_wait <= 1'b0;
                    end
                end
                ST_PREAMBLE: begin
                    if (!bx_wait) begin
                        bx_wait <= 1'b1;
                    end else if (bx_done_i) begin
                        bx_wait <= 1'b0;
                        if (pre_cnt == PC_W'(PRE_TOTAL - 1)) begin
                            st      <= ST_RESET;
                            go_sent <= 1'b0;
                        end else begin
                            pre_cnt <= pre_cnt + 1'b1;
                            if (pre_cnt == PC_W'(PRE_BYTES)) begin
                                cs_high_o <= 1'b0;
                            end
                        end
                    end
                end
                ST_RESET: begin
                    if (!go_sent) begin
                        go_sent <= 1'b1;
                    end else if (resp_valid_i) begin
                        if (resp_i == RESP_IDLE) begin
                            st       <= ST_POLL;
                            poll_cnt <= '0;
                            go_sent  <= 1'b0;
                        end else begin
                            err_stage_o <= 1'b0;
                            err_code_o  <= resp_i;
                            st          <= ST_ERROR;
                            cs_high_o   <= 1'b1;
                            tail_busy   <= 1'b1;
                            bx_wait     <= 1'b0;
                        end
                    end
                end
                ST_POLL: begin
                    if (!go_sent) begin
                        go_sent <= 1'b1;
                    end else if (resp_valid_i) begin
                        if (resp_i == RESP_READY) begin
                            st        <= ST_DONE;
                            cs_high_o <= 1'b1;
                            tail_busy <= 1'b1;
                            bx_wait   <= 1'b0;
                        end else if (poll_cnt == PL_W'(POLL_MAX - 1)) begin
                            err_stage_o <= 1'b1;
                            err_code_o  <= resp_i;
                            st          <= ST_ERROR;
                            cs_high_o   <= 1'b1;
                            tail_busy   <= 1'b1;
                            bx_wait     <= 1'b0;
                        end else begin
                            poll_cnt <= poll_cnt + 1'b1;
                            go_sent  <= 1'b0;
                        end
                    end
                end
                ST_DONE, ST_ERROR: begin
                    if (tail_busy) begin
                        if (!bx_wait) begin
                            bx_wait <= 1'b1;
                        end else if (bx_done_i) begin
                            bx_wait   <= 1'b0;
                            tail_busy <= 1'b0;
                        end
                    end else if (start_i) begin
                        st      <= ST_PREAMBLE;
                        pre_cnt <= '0;
                        bx_wait <= 1'b0;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Command selection, filler requests and result flags.
    always_comb begin
        use_framer_o = (st == ST_RESET) || (st == ST_POLL);
        cmd_go_o     = use_framer_o && !go_sent;
        cmd_idx_o    = (st == ST_POLL) ? IDX_POLL : IDX_RESET;
        cmd_crc_o    = (st == ST_POLL) ? FILL_BYTE : CRC_RESET;
        bx_start_o   = !bx_wait && ((st == ST_PREAMBLE) ||
                       (((st == ST_DONE) || (st == ST_ERROR)) && tail_busy));
        init_done_o  = (st == ST_DONE)  && !tail_busy;
        init_err_o   = (st == ST_ERROR) && !tail_busy;
    end

endmodule

// File: rtl/card_spi_init.sv
// Module: card_spi_init (top)
// Memory-card SPI start-up sequencer: controller, command framer and the
// byte-port arbiter. Talks to an external byte shifter by start/done pulses.
// Assumes: the shifter answers each start with exactly one done pulse, at
// least one cycle later.
module card_spi_init
    import card_spi_init_pkg::*;
#(
    parameter int PRE_BYTES   = 10,
    parameter int POLL_MAX    = 8,
    parameter int RESP_WINDOW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic       xfer_start_o,
    output logic [7:0] xfer_tx_o,
    input  logic       xfer_done_i,
    input  logic [7:0] xfer_rx_i,
    output logic       card_cs_o,
    output logic       init_done_o,
    output logic       init_err_o,
    output logic       err_stage_o,
    output logic [7:0] err_code_o
);

    logic       cmd_go;
    logic [5:0] cmd_idx;
    logic [7:0] cmd_crc;
    logic       resp_valid;
    logic [7:0] resp;
    logic       use_framer;
    logic       frm_active;
    logic       ctrl_start;
    logic       ctrl_done;
    logic       frm_start;
    logic [7:0] frm_tx;
    logic       frm_done;

    card_spi_init_ctrl #(
        .PRE_BYTES (PRE_BYTES),
        .POLL_MAX  (POLL_MAX)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .cmd_go_o     (cmd_go),
        .cmd_idx_o    (cmd_idx),
        .cmd_crc_o    (cmd_crc),
        .resp_valid_i (resp_valid),
        .resp_i       (resp),
        .use_framer_o (use_framer),
        .bx_start_o   (ctrl_start),
        .bx_done_i    (ctrl_done),
        .cs_high_o    (card_cs_o),
        .init_done_o  (init_done_o),
        .init_err_o   (init_err_o),
        .err_stage_o  (err_stage_o),
        .err_code_o   (err_code_o)
    );

    card_spi_init_framer #(
        .RESP_WINDOW (RESP_WINDOW)
    ) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (cmd_go),
        .cmd_i        (cmd_idx),
        .arg_i        (32'h0000_0000),
        .crc_i        (cmd_crc),
        .resp_valid_o (resp_valid),
        .resp_o       (resp),
        .active_o     (frm_active),
        .bx_start_o   (frm_start),
        .bx_tx_o      (frm_tx),
        .bx_done_i    (frm_done),
        .bx_rx_i      (xfer_rx_i)
    );

    // The framer also owns the port while it is still finishing a response.
    card_spi_init_port_mux u_mux (
        .sel_framer_i (use_framer || frm_active),
        .ctrl_start_i (ctrl_start),
        .ctrl_tx_i    (FILL_BYTE),
        .frm_start_i  (frm_start),
        .frm_tx_i     (frm_tx),
        .done_i       (xfer_done_i),
        .start_o      (xfer_start_o),
        .tx_o         (xfer_tx_o),
        .ctrl_done_o  (ctrl_done),
        .frm_done_o   (frm_done)
    );

endmodule

// File: rtl/card_spi_init_chk.sv
// Module: card_spi_init_chk
// Protocol and result checks on the sequencer's ports, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module card_spi_init_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       xfer_start_o,
    input logic       xfer_done_i,
    input logic       card_cs_o,
    input logic       init_done_o,
    input logic       init_err_o,
    input logic [7:0] err_code_o
);

    logic pending;

    // Track whether a byte exchange is outstanding.
    always_ff @(posedge clk) begin
        if (!rst_n)            pending <= 1'b0;
        else if (xfer_start_o) pending <= 1'b1;
        else if (xfer_done_i)  pending <= 1'b0;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (card_cs_o && !init_done_o && !init_err_o));

    assert_start_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |=> !xfer_start_o);

    assert_no_overlap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start_o |-> !pending);

    assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(init_done_o && init_err_o));

    assert_flag_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done_o || init_err_o) |-> card_cs_o);

    assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (init_err_o && $past(init_err_o)) |-> $stable(err_code_o));

    assert_busy_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !card_cs_o |=> (!init_done_o && !init_err_o));

endmodule

bind card_spi_init card_spi_init_chk u_chk (.*);

// File: tb/test_card_spi_init.sv
// Bench: card model behind a byte shifter, directed corner cases plus
// seeded random runs, expected results computed from the requirements.
module test_card_spi_init;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic       xfer_start;
    logic [7:0] xfer_tx;
    logic       xfer_done;
    logic [7:0] xfer_rx;
    logic       card_cs;
    logic       init_done;
    logic       init_err;
    logic       err_stage;
    logic [7:0] err_code;

    always #10 clk = ~clk;

    card_spi_init i_card_spi_init (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .xfer_start_o (xfer_start),
        .xfer_tx_o    (xfer_tx),
        .xfer_done_i  (xfer_done),
        .xfer_rx_i    (xfer_rx),
        .card_cs_o    (card_cs),
        .init_done_o  (init_done),
        .init_err_o   (init_err),
        .err_stage_o  (err_stage),
        .err_code_o   (err_code)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Card configuration.
    int m_reset_resp, m_reset_lat, m_poll_lat, m_ready_at, m_busy;
    // Card state and observation counters.
    int c_high, c_high_nonff, c_gap, c_cmd0, c_cmd1, c_bad;
    int seen_low, seen_frame, in_frame, pos, fcmd, pend, pend_lat, pend_val;
    int last_cs, last_tx;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        c_high = 0; c_high_nonff = 0; c_gap = 0; c_cmd0 = 0; c_cmd1 = 0; c_bad = 0;
        seen_low = 0; seen_frame = 0; in_frame = 0; pos = 0; fcmd = 0;
        pend = 0; pend_lat = 0; pend_val = 255; last_cs = 1; last_tx = 255;
    endtask

    // One byte exchange as seen by the card.
    task automatic card_byte(input int tx, input int cs, output int rx);
        last_cs = cs; last_tx = tx; rx = 255;
        if (cs != 0) begin
            if (seen_low == 0) begin
                c_high++;
                if (tx != 255) c_high_nonff++;
            end
        end else begin
            seen_low = 1;
            if (pend != 0) begin
                if (pend_lat == 0) begin rx = pend_val; pend = 0; end
                else pend_lat--;
            end
            if (in_frame != 0) begin
                if (pos < 5 && tx != 0) c_bad++;
                if (pos == 5 && tx != ((fcmd == 0) ? 8'h95 : 8'hFF)) c_bad++;
                pos++;
                if (pos == 6) begin
                    in_frame = 0;
                    pend = 1;
                    if (fcmd == 0) begin
                        c_cmd0++;
                        pend_lat = m_reset_lat;
                        pend_val = m_reset_resp;
                    end else begin
                        c_cmd1++;
                        pend_lat = m_poll_lat;
                        pend_val = (m_ready_at != 0 && c_cmd1 >= m_ready_at) ? 0 : m_busy;
                    end
                end
            end else if (tx != 255) begin
                if (tx == 8'h40 || tx == 8'h41) begin
                    in_frame = 1; pos = 1; fcmd = tx & 8'h3F; seen_frame = 1;
                end else c_bad++;
            end else if (seen_frame == 0) c_gap++;
        end
    endtask

    // Byte shifter model with a random completion delay.
    initial begin
        int rb;
        xfer_done = 1'b0;
        xfer_rx   = 8'hFF;
        @(posedge rst_n);
        @(negedge clk);
        forever begin
            if (xfer_start) begin
                card_byte(int'(xfer_tx), int'(card_cs), rb);
                repeat (1 + $urandom % 3) @(negedge clk);
                xfer_rx   = rb[7:0];
                xfer_done = 1'b1;
                @(negedge clk);
                xfer_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog.
    initial begin
        repeat (180000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        summary();
        $finish;
    end

    // One full sequence against the configured card.
    task automatic run(input int rresp, input int rlat, input int plat, input int ready,
                       input int busy, input int restart, input int mid);
        int t, e_done, e_err, e_stage, e_code, e_polls;
        string tag;
        m_reset_resp = rresp; m_reset_lat = rlat; m_poll_lat = plat;
        m_ready_at = ready; m_busy = busy;
        model_clear();
        // Expected outcome from the requirements.
        e_stage = 0; e_code = 0;
        if (rlat > 7) begin
            e_done = 0; e_err = 1; e_stage = 0; e_code = 255; e_polls = 0; tag = "R5";
        end else if (rresp != 1) begin
            e_done = 0; e_err = 1; e_stage = 0; e_code = rresp; e_polls = 0; tag = "R6";
        end else if (ready >= 1 && ready <= 8) begin
            e_done = 1; e_err = 0; e_polls = ready; tag = "R7";
        end else begin
            e_done = 0; e_err = 1; e_stage = 1; e_code = busy; e_polls = 8; tag = "R8";
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart != 0) begin
            check("R11", "done cleared on restart", int'(init_done), 0);
            check("R11", "error cleared on restart", int'(init_err), 0);
        end
        if (mid != 0) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (!(init_done || init_err) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check("R9", "sequence finished", int'(t < 20000), 1);
        check(tag, "done flag", int'(init_done), e_done);
        check(tag, "error flag", int'(init_err), e_err);
        if (e_err != 0) begin
            check(tag, "error stage", int'(err_stage), e_stage);
            check(tag, "error code", int'(err_code), e_code);
        end
        check(tag, "readiness commands sent", c_cmd1, e_polls);
        check((mid != 0) ? "R10" : "R4", "reset commands sent", c_cmd0, 1);
        check((mid != 0) ? "R10" : "R2", "deselected bytes before select", c_high, 11);
        check("R2", "non-filler deselected bytes", c_high_nonff, 0);
        check("R3", "filler bytes after select", c_gap, 1);
        check("R4", "malformed frame bytes", c_bad, 0);
        check("R9", "closing byte deselected", last_cs, 1);
        check("R9", "closing byte is filler", last_tx, 255);
        check("R9", "chip select high at end", int'(card_cs), 1);
    endtask

    task automatic hw_reset();
        rst_n = 1'b0;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5EED));
        hw_reset();
        // R1: idle after reset, nothing starts by itself.
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R1", "chip select after reset", int'(card_cs), 1);
            check("R1", "flags after reset", int'(init_done || init_err), 0);
            check("R1", "no exchange without start", int'(xfer_start), 0);
        end
        // Directed corner cases.
        run(1, 0, 0, 1, 1, 0, 0);         // R7 ready on first poll
        run(5, 2, 0, 1, 1, 1, 0);         // R6 wrong reset reply
        run(1, 7, 3, 8, 1, 1, 0);         // R5 latest reply position, R7 last poll
        run(1, 8, 0, 1, 1, 1, 0);         // R5 reply one byte too late
        run(1, 1, 2, 0, 1, 1, 0);         // R8 never ready
        run(1, 0, 7, 0, 8'h05, 1, 0);     // R8 last reply captured
        run(0, 0, 0, 1, 1, 1, 0);         // R6 ready reply to reset is an error
        run(1, 3, 1, 3, 1, 1, 1);         // R10 start while running
        hw_reset();
        run(1, 0, 0, 2, 1, 0, 0);         // after a fresh reset
        // Seeded random runs.
        for (int k = 0; k < 22; k++) begin
            int rr, rl, pl, ra, bz;
            rr = ($urandom % 4 == 0) ? int'($urandom % 256) : 1;
            rl = int'($urandom % 8);
            pl = int'($urandom % 8);
            ra = int'($urandom % 10);
            bz = ($urandom % 2 == 0) ? 1 : int'($urandom % 255) + 1;
            run(rr, rl, pl, ra, bz, 1, int'($urandom % 3 == 0));
        end
        summary();
        $finish;
    end

endmodule